// File: doc/BRIEF.md
# Quadlet-Staging Host Bus Interface

This block connects a plain microprocessor bus to a bank of 32-bit registers. The bus has an active-low chip select, separate active-low read and write strobes, an address latch strobe, a WAIT output, nine address bits and a data path of 8 or 16 bits. The host moves a quadlet a byte or a halfword at a time. Each piece goes through a 32-bit staging register. The top address bit marks the access that touches the bank itself. On a read it is the first access of the quadlet: the whole register is copied into staging in one step, so the later lane reads all come from the same snapshot. On a write it is the last access: the assembled staging word is stored in one step.

Two static mode pins set the bus shape. One selects 8-bit or 16-bit data. The other selects where the low address byte comes from: either dedicated address lines, or the low data lines, captured while the latch strobe is high. The host strobes are brought into the internal clock domain through two-flop synchronisers. WAIT holds the host until each access has been handled. A status input is turned into an active-low interrupt output that is either driven low or released.

Top module: `qhb_bridge`

## Requirements
- R1: After reset the staging word is zero. The bank strobes are low, the data enables are low and `irq_n` is high (released). While no access is active, `host_wait` is low.
- R2: In 8-bit mode (`host_wide`=0), address bits [1:0] select the byte lane of the staging word, with lane 0 the least significant byte. Only `host_data_lo_*` carries data and `host_data_hi_oe` stays low.
- R3: In 16-bit mode (`host_wide`=1), address bit 1 selects the halfword. The low data lines carry bits [7:0] of that halfword and the high data lines carry bits [15:8]. Address bit 0 has no effect.
- R4: In multiplexed mode (`host_mux`=1), the low address byte is taken from `host_data_lo_in` while `host_ale` is high, and `host_addr_lo` is ignored. In non-multiplexed mode it comes from `host_addr_lo`.
- R5: A write with `host_addr_hi`=1 stores the assembled staging word, including the data of that access, into register `addr[7:2]`. It does so with exactly one cycle of `reg_wr_en`.
- R6: A write with `host_addr_hi`=0 changes only the staging word. The bank sees no store and the register keeps its value.
- R7: A read with `host_addr_hi`=1 fetches register `addr[7:2]` into staging with exactly one cycle of `reg_rd_en`. Later reads without that bit return lanes of this snapshot, even if the register has changed since.
- R8: With chip select low, a low write strobe makes the access a write, even when the read strobe is low too.
- R9: `host_wait` goes high as soon as chip select and a strobe are both low. It stays high until the access is handled, including the bank access when `host_addr_hi`=1. Read data is valid once it drops.
- R10: `irq_n` is low one clock after `irq_src` is high and is high one clock after it is low.
- R11: `rst_n` low resets the block at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_ale | input | 1 | Address latch strobe (multiplexed mode) |
| host_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| host_mux | input | 1 | 1 = low address byte on low data lines |
| host_addr_hi | input | 1 | Address bit 8: quadlet fetch/store marker |
| host_addr_lo | input | ADDR_LO_W | Dedicated low address lines |
| host_data_lo_in | input | 8 | Low data lines, host to block |
| host_data_hi_in | input | 8 | High data lines, host to block |
| host_data_lo_out | output | 8 | Low data lines, block to host |
| host_data_hi_out | output | 8 | High data lines, block to host |
| host_data_lo_oe | output | 1 | Block drives low data lines |
| host_data_hi_oe | output | 1 | Block drives high data lines |
| host_wait | output | 1 | Host must hold the access |
| irq_src | input | 1 | Interrupt status, active high |
| irq_n | output | 1 | Interrupt, 0 = drive low, 1 = released |
| reg_sel | output | ADDR_LO_W-2 | Register index for the bank |
| reg_rd_en | output | 1 | Bank fetch strobe |
| reg_rdata | input | 32 | Bank read data for `reg_sel` |
| reg_wr_en | output | 1 | Bank store strobe |
| reg_wdata | output | 32 | Bank write data |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle. Each bank strobe lasts exactly one cycle. A store happens only during a write access that carries the top address bit, and a fetch only during a read access that carries it. The high data lanes are driven only in 16-bit mode. WAIT stays low while chip select is high. The interrupt output follows its source one clock later. Only the bench scenarios can show the remaining behaviours. These are the lane placement in all four bus shapes, the snapshot kept across a register change, partial writes that leave the register untouched, and the write priority when both strobes are low. The bench also shows the immediate effect of the asynchronous reset.

// File: rtl/qhb_pkg.sv
package qhb_pkg;
    localparam int QUAD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BANK,
        PH_HOLD
    } phase_e;

    // Insert one byte (narrow) or one halfword (wide) into the staging word.
    function automatic logic [QUAD_W-1:0] stage_merge(
        input logic [QUAD_W-1:0] cur,
        input logic [1:0]        lane,
        input logic              wide,
        input logic [BYTE_W-1:0] lo,
        input logic [BYTE_W-1:0] hi
    );
        logic [QUAD_W-1:0] r;
        int                base;
        r = cur;
        if (wide) begin
            base = lane[1] ? 16 : 0;
            r[base +: BYTE_W]          = lo;
            r[base + BYTE_W +: BYTE_W] = hi;
        end else begin
            base = 8 * int'(lane);
            r[base +: BYTE_W] = lo;
        end
        return r;
    endfunction
endpackage

// File: rtl/qhb_sync.sv
module qhb_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/qhb_lane_read.sv
module qhb_lane_read
    import qhb_pkg::*;
(
    input  logic [QUAD_W-1:0] stage,
    input  logic [1:0]        lane,
    input  logic              wide,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi
);
    always_comb begin
        int half_base;
        half_base = lane[1] ? 16 : 0;
        if (wide) begin
            lo = stage[half_base +: BYTE_W];
        end else begin
            lo = stage[8 * int'(lane) +: BYTE_W];
        end
        hi = stage[half_base + BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/qhb_irq_drv.sv
module qhb_irq_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic irq_n
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_n = ~pend_q;
endmodule

// File: rtl/qhb_bridge.sv
module qhb_bridge
    import qhb_pkg::*;
#(
    parameter int ADDR_LO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_cs_n,
    input  logic                 host_rd_n,
    input  logic                 host_wr_n,
    input  logic                 host_ale,
    input  logic                 host_wide,
    input  logic                 host_mux,
    input  logic                 host_addr_hi,
    input  logic [ADDR_LO_W-1:0] host_addr_lo,
    input  logic [7:0]           host_data_lo_in,
    input  logic [7:0]           host_data_hi_in,
    output logic [7:0]           host_data_lo_out,
    output logic [7:0]           host_data_hi_out,
    output logic                 host_data_lo_oe,
    output logic                 host_data_hi_oe,
    output logic                 host_wait,
    input  logic                 irq_src,
    output logic                 irq_n,
    output logic [ADDR_LO_W-3:0] reg_sel,
    output logic                 reg_rd_en,
    input  logic [31:0]          reg_rdata,
    output logic                 reg_wr_en,
    output logic [31:0]          reg_wdata
);
    localparam int SEL_W = ADDR_LO_W - 2;

    typedef struct packed {
        phase_e                 phase;
        logic [QUAD_W-1:0]      stage;
        logic [ADDR_LO_W-1:0]   addr;
        logic                   is_wr;
        logic [ADDR_LO_W-1:0]   mux_addr;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    // Synchronised strobes: {ale, cs_n, rd_n, wr_n}
    logic [3:0] strb_s;
    logic       ale_s, cs_s_n, rd_s_n, wr_s_n;

    qhb_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({host_ale, host_cs_n, host_rd_n, host_wr_n}),
        .dout  (strb_s)
    );

    assign {ale_s, cs_s_n, rd_s_n, wr_s_n} = strb_s;

    logic                 act_s;
    logic [ADDR_LO_W-1:0] eff_addr;

    assign act_s    = !cs_s_n && (!wr_s_n || !rd_s_n);
    assign eff_addr = host_mux ? ctl_q.mux_addr : host_addr_lo;

    always_comb begin
        ctl_d = ctl_q;
        if (ale_s) begin
            ctl_d.mux_addr = ADDR_LO_W'(host_data_lo_in);
        end
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (act_s) begin
                    ctl_d.addr  = eff_addr;
                    ctl_d.is_wr = !wr_s_n;
                    if (!wr_s_n) begin
                        ctl_d.stage = stage_merge(ctl_q.stage, eff_addr[1:0],
                                                  host_wide, host_data_lo_in,
                                                  host_data_hi_in);
                    end
                    ctl_d.phase = host_addr_hi ? PH_BANK : PH_HOLD;
                end
            end
            PH_BANK: begin
                if (!ctl_q.is_wr) begin
                    ctl_d.stage = reg_rdata;
                end
                ctl_d.phase = PH_HOLD;
            end
            PH_HOLD: begin
                if (!act_s) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, stage: '0, addr: '0, is_wr: 1'b0,
                       mux_addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    qhb_lane_read u_lane (
        .stage (ctl_q.stage),
        .lane  (ctl_q.addr[1:0]),
        .wide  (host_wide),
        .lo    (host_data_lo_out),
        .hi    (host_data_hi_out)
    );

    qhb_irq_drv u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (irq_src),
        .irq_n (irq_n)
    );

    assign reg_sel         = ctl_q.addr[ADDR_LO_W-1:2];
    assign reg_wr_en       = (ctl_q.phase == PH_BANK) && ctl_q.is_wr;
    assign reg_rd_en       = (ctl_q.phase == PH_BANK) && !ctl_q.is_wr;
    assign reg_wdata       = ctl_q.stage;
    assign host_data_lo_oe = (ctl_q.phase == PH_HOLD) && !ctl_q.is_wr;
    assign host_data_hi_oe = host_data_lo_oe && host_wide;
    assign host_wait       = !host_cs_n && (!host_rd_n || !host_wr_n)
                             && (ctl_q.phase != PH_HOLD);

    logic unused_sel_w;
    assign unused_sel_w = (SEL_W > 0);
endmodule

// File: rtl/qhb_bridge_chk.sv
module qhb_bridge_chk #(
    parameter int ADDR_LO_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic host_cs_n,
    input logic host_rd_n,
    input logic host_wr_n,
    input logic host_wide,
    input logic host_addr_hi,
    input logic host_data_hi_oe,
    input logic host_wait,
    input logic irq_src,
    input logic irq_n,
    input logic reg_rd_en,
    input logic reg_wr_en
);
    // R5
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R7
    rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);
    // R5
    store_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (host_addr_hi && !host_cs_n && !host_wr_n));
    // R7
    fetch_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (host_addr_hi && !host_cs_n && !host_rd_n && host_wr_n));
    // R3
    hi_lane_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_hi_oe |-> host_wide);
    // R1
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> !host_wait);
    // R10
    irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_src |=> !irq_n);
    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_src |=> irq_n);
endmodule

bind qhb_bridge qhb_bridge_chk #(.ADDR_LO_W(ADDR_LO_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_cs_n       (host_cs_n),
    .host_rd_n       (host_rd_n),
    .host_wr_n       (host_wr_n),
    .host_wide       (host_wide),
    .host_addr_hi    (host_addr_hi),
    .host_data_hi_oe (host_data_hi_oe),
    .host_wait       (host_wait),
    .irq_src         (irq_src),
    .irq_n           (irq_n),
    .reg_rd_en       (reg_rd_en),
    .reg_wr_en       (reg_wr_en)
);

// File: tb/qhb_bridge_test.sv
module qhb_bridge_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic        host_ale = 1'b0, host_wide = 1'b0, host_mux = 1'b0;
    logic        host_addr_hi = 1'b0;
    logic [7:0]  host_addr_lo = '0;
    logic [7:0]  host_data_lo_in = '0, host_data_hi_in = '0;
    logic [7:0]  host_data_lo_out, host_data_hi_out;
    logic        host_data_lo_oe, host_data_hi_oe, host_wait;
    logic        irq_src = 1'b0, irq_n;
    logic [5:0]  reg_sel;
    logic        reg_rd_en, reg_wr_en;
    logic [31:0] reg_rdata, reg_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    qhb_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_ale(host_ale), .host_wide(host_wide),
        .host_mux(host_mux), .host_addr_hi(host_addr_hi),
        .host_addr_lo(host_addr_lo), .host_data_lo_in(host_data_lo_in),
        .host_data_hi_in(host_data_hi_in), .host_data_lo_out(host_data_lo_out),
        .host_data_hi_out(host_data_hi_out), .host_data_lo_oe(host_data_lo_oe),
        .host_data_hi_oe(host_data_hi_oe), .host_wait(host_wait),
        .irq_src(irq_src), .irq_n(irq_n), .reg_sel(reg_sel),
        .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata)
    );

    // Register bank model
    logic [31:0] bank [64];
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    int          wr_pulses = 0, rd_pulses = 0;

    assign reg_rdata = bank[reg_sel];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            bank[reg_sel] <= reg_wdata;
            wr_pulses     <= wr_pulses + 1;
        end else if (poke_en) begin
            bank[poke_idx] <= poke_val;
        end
        if (reg_rd_en) rd_pulses <= rd_pulses + 1;
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard: {hi_oe, hi, lo_oe, lo}
    typedef struct { logic [17:0] val; string req; } item_t;
    item_t exp_q[$];
    logic [17:0] act_q[$];

    initial begin
        forever begin
            item_t       e;
            logic [17:0] a;
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            chk(a == e.val, e.req, 32'(a), 32'(e.val));
        end
    end

    task automatic bus_cycle(input bit do_wr, input bit both, input bit last,
                             input logic [7:0] a, input logic [7:0] dlo,
                             input logic [7:0] dhi);
        int n;
        @(negedge clk);
        if (host_mux) begin
            host_data_lo_in = a;
            host_addr_lo    = ~a;        // R4: dedicated lines hold garbage
            host_ale        = 1'b1;
            repeat (2) @(negedge clk);
            host_ale = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            host_addr_lo = a;
        end
        host_addr_hi    = last;
        host_data_lo_in = do_wr ? dlo : 8'h00;
        host_data_hi_in = dhi;
        host_cs_n       = 1'b0;
        if (do_wr) begin
            host_wr_n = 1'b0;
            host_rd_n = both ? 1'b0 : 1'b1;
        end else begin
            host_rd_n = 1'b0;
        end
        #1;
        chk(host_wait == 1'b1, "R9 wait raised", 32'(host_wait), 32'd1);
        n = 0;
        while (host_wait && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!do_wr) begin
            act_q.push_back({host_data_hi_oe, host_data_hi_oe ? host_data_hi_out : 8'h00,
                             host_data_lo_oe, host_data_lo_out});
        end
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_addr_hi = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_quad(input logic [5:0] idx, input logic [31:0] v,
                           input bit both);
        if (host_wide) begin
            for (int h = 0; h < 2; h++)
                bus_cycle(1, both, h == 1, {idx, h[0], 1'b0},
                          v[16*h +: 8], v[16*h+8 +: 8]);
        end else begin
            for (int b = 0; b < 4; b++)
                bus_cycle(1, both, b == 3, {idx, b[1:0]}, v[8*b +: 8], 8'h00);
        end
    endtask

    task automatic push_exp(input logic [31:0] v, input int lane, input string req);
        item_t e;
        e.req = req;
        if (host_wide) e.val = {1'b1, v[16*lane+8 +: 8], 1'b1, v[16*lane +: 8]};
        else           e.val = {1'b0, 8'h00, 1'b1, v[8*lane +: 8]};
        exp_q.push_back(e);
    endtask

    task automatic rd_quad(input logic [5:0] idx, input logic [31:0] v,
                           input string req);
        if (host_wide) begin
            for (int h = 0; h < 2; h++) begin
                push_exp(v, h, req);
                bus_cycle(0, 0, h == 0, {idx, h[0], 1'b1}, 8'h00, 8'h00); // R3 addr bit0 set
            end
        end else begin
            for (int b = 0; b < 4; b++) begin
                push_exp(v, b, req);
                bus_cycle(0, 0, b == 0, {idx, b[1:0]}, 8'h00, 8'h00);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reg_wr_en == 0 && reg_rd_en == 0, "R1 bank strobes", {reg_wr_en, reg_rd_en}, 0);
        chk(irq_n == 1 && host_wait == 0, "R1 irq/wait", {irq_n, host_wait}, 32'h2);
        chk(host_data_lo_oe == 0 && reg_wdata == 0, "R1 staging/oe", reg_wdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int m = 0; m < 4; m++) begin
            logic [5:0]  idx;
            logic [31:0] v;
            string       tag;
            host_wide = m[0];
            host_mux  = m[1];
            idx = 6'(10 + m);
            v   = 32'h1234_5678 ^ (32'h1111_0F0F * (m + 1));
            tag = host_wide ? "R3 R4 R5 wide" : "R2 R4 R5 narrow";
            w0 = wr_pulses;
            wr_quad(idx, v, 0);
            chk(bank[idx] == v, tag, bank[idx], v);
            chk(wr_pulses == w0 + 1, "R5 one store", wr_pulses, w0 + 1);
            rd_quad(idx, v, host_wide ? "R3 R7 wide read" : "R2 R7 narrow read");
        end

        // R6: partial writes without the marker bit
        host_wide = 0; host_mux = 0;
        bank_seed(6'd5, 32'hCAFE_F00D);
        w0 = wr_pulses;
        for (int b = 0; b < 3; b++) bus_cycle(1, 0, 0, {6'd5, b[1:0]}, 8'hA0 + 8'(b), 8'h00);
        chk(bank[5] == 32'hCAFE_F00D, "R6 register unchanged", bank[5], 32'hCAFE_F00D);
        chk(wr_pulses == w0, "R6 no store", wr_pulses, w0);

        // R7: snapshot across a register change
        bank_seed(6'd7, 32'h4433_2211);
        r0 = rd_pulses;
        push_exp(32'h4433_2211, 0, "R7 snapshot");
        bus_cycle(0, 0, 1, {6'd7, 2'd0}, 8'h00, 8'h00);
        bank_seed(6'd7, 32'h9988_7766);
        for (int b = 1; b < 4; b++) begin
            push_exp(32'h4433_2211, b, "R7 snapshot");
            bus_cycle(0, 0, 0, {6'd7, b[1:0]}, 8'h00, 8'h00);
        end
        chk(rd_pulses == r0 + 1, "R7 one fetch", rd_pulses, r0 + 1);

        // R8: both strobes low is a write
        host_wide = 1;
        wr_quad(6'd20, 32'h0BAD_BEEF, 1);
        chk(bank[20] == 32'h0BAD_BEEF, "R8 both strobes write", bank[20], 32'h0BAD_BEEF);

        // R10 interrupt
        @(negedge clk); irq_src = 1'b1;
        @(negedge clk);
        chk(irq_n == 1'b0, "R10 irq asserted", irq_n, 0);
        irq_src = 1'b0;
        @(negedge clk);
        chk(irq_n == 1'b1, "R10 irq released", irq_n, 1);

        // R11 asynchronous reset
        irq_src = 1'b1;
        repeat (2) @(negedge clk);
        #2 rst_n = 1'b0;
        #1 chk(irq_n == 1'b1, "R11 async reset", irq_n, 1);
        irq_src = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        wait (act_q.size() == 0);
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic bank_seed(input logic [5:0] i, input logic [31:0] v);
        @(negedge clk);
        poke_idx = i; poke_val = v; poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask
endmodule